// File: doc/BRIEF.md
# Least-Recently-Used Tag Store

This block is the tag side of a fully associative cache with 256 rows. It keeps one entry per row: a valid flag, a 14-bit tag and a 5-bit age counter. A search compares one tag against every entry at the same time. One cycle later the block reports either a hit together with the matching row number, which is used to address the data array, or a miss. After every accepted search it also gives a replacement row.

The counters track recency. When a row is touched (read or written) or filled, its counter goes to zero. The counter of every other valid row goes up by one and stops at 31. The replacement row is chosen in this order: first an invalid row; if every row is valid, the row with the largest age. Ties go to the lowest row number. A fill writes the new tag into the replacement row given by the most recent accepted search and marks that row valid. A fill always takes precedence. A search in the same cycle as a fill is dropped, and a touch in the same cycle as a fill is ignored.

A three-state controller holds the result of the last cycle. The states are ST_IDLE (no accepted search), ST_HIT (the accepted search matched) and ST_MISS (the accepted search did not match). Every state has the same three transitions. An accepted search with a match goes to ST_HIT. An accepted search with no match goes to ST_MISS. Anything else, including a search dropped because of a fill, goes to ST_IDLE.

Top module: `lru_tag_cam`

## Requirements
- R1: After reset all rows are invalid and all ages are zero. hit_o and miss_o are 0 and victim_row_o is 0. A search for any tag, including tag 0, then misses.
- R2: A search accepted in cycle N gives, in cycle N+1, exactly one of hit_o or miss_o. hit_o is set only when a valid row holds the searched tag, and hit_row_o then gives that row's index. In a cycle after no accepted search, both hit_o and miss_o are 0.
- R3: victim_row_o is updated only in the cycle after an accepted search, whether it hit or missed. It holds its value until the next accepted search.
- R4: When at least one row is invalid at the time of the search, victim_row_o is the lowest-numbered invalid row.
- R5: When every row is valid, victim_row_o is the row with the largest age. Among rows of equal age, the lowest index wins.
- R6: A touch of row r clears the age of r. The age of every other valid row rises by one and stays at 31 once it reaches 31.
- R7: A fill writes fill_tag into row victim_row_o, sets that row valid and clears its age. Every other valid row ages as in R6. The tag that row held before no longer hits.
- R8: When a fill and a search arrive in the same cycle, the search is dropped. In the next cycle hit_o and miss_o are 0 and victim_row_o keeps its value.
- R9: No more than one row matches a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_en | input | 1 | Start a search with srch_tag |
| srch_tag | input | 14 | Tag to look up |
| touch_en | input | 1 | Mark row touch_row as just used |
| touch_row | input | 8 | Row being touched |
| fill_en | input | 1 | Write fill_tag into the current replacement row |
| fill_tag | input | 14 | Tag to store on a fill |
| hit_o | output | 1 | Last accepted search matched |
| miss_o | output | 1 | Last accepted search did not match |
| hit_row_o | output | 8 | Row that matched the last accepted search |
| victim_row_o | output | 8 | Replacement row chosen at the last accepted search |

## Verification
A wrong valid bit or tag shows at the ports one cycle after the next search of that tag, as a false hit, a false miss or a wrong hit_row_o. A wrong age counter stays hidden until every row is valid and that row competes for replacement. For this reason the bench runs long touch sequences past the point of saturation and then checks the replacement row against an independent model. A skipped fill or a misdirected fill shows as a miss, or as a stale hit, on the next search of either the old tag or the new one.

// File: rtl/lru_cam_pkg.sv
package lru_cam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } cam_state_e;

endpackage

// File: rtl/lru_cam_entry.sv
module lru_cam_entry #(
    parameter int TAG_W = 14,
    parameter int AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] srch_tag,
    input  logic             acc_en,
    input  logic             acc_sel,
    input  logic             wr_sel,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             valid_o,
    output logic [AGE_W-1:0] age_o,
    output logic             match_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            age_q   <= '0;
        end else begin
            if (wr_sel) begin
                valid_q <= 1'b1;
                tag_q   <= wr_tag;
            end
            if (acc_sel) begin
                age_q <= '0;
            end else if (acc_en && valid_q && (age_q != AGE_MAX)) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign age_o   = age_q;
    assign match_o = valid_q && (tag_q == srch_tag);

endmodule

// File: rtl/lru_cam_enc.sv
module lru_cam_enc #(
    parameter int ROWS  = 256,
    parameter int IDX_W = 8
) (
    input  logic [ROWS-1:0]  match_vec,
    output logic [IDX_W-1:0] match_idx,
    output logic             match_any
);

    always_comb begin
        match_idx = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (match_vec[r]) begin
                match_idx = match_idx | IDX_W'(r);
            end
        end
    end

    assign match_any = |match_vec;

endmodule

// File: rtl/lru_cam_victim.sv
module lru_cam_victim #(
    parameter int ROWS  = 256,
    parameter int AGE_W = 5,
    parameter int IDX_W = 8
) (
    input  logic [ROWS-1:0]       row_valid,
    input  logic [ROWS*AGE_W-1:0] age_flat,
    output logic [IDX_W-1:0]      victim_idx
);

    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] nd_inv;
    logic [AGE_W-1:0] nd_age [NODES];
    logic [IDX_W-1:0] nd_idx [NODES];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < ROWS) begin : g_real
            assign nd_inv[LEAVES-1+k] = !row_valid[k];
            assign nd_age[LEAVES-1+k] = age_flat[k*AGE_W +: AGE_W];
        end else begin : g_pad
            assign nd_inv[LEAVES-1+k] = 1'b0;
            assign nd_age[LEAVES-1+k] = '0;
        end
        assign nd_idx[LEAVES-1+k] = IDX_W'(k);
    end

    for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
        logic take_r;
        assign take_r = (nd_inv[2*i+2] && !nd_inv[2*i+1]) ||
                        (!nd_inv[2*i+2] && !nd_inv[2*i+1] &&
                         (nd_age[2*i+2] > nd_age[2*i+1]));
        assign nd_inv[i] = take_r ? nd_inv[2*i+2] : nd_inv[2*i+1];
        assign nd_age[i] = take_r ? nd_age[2*i+2] : nd_age[2*i+1];
        assign nd_idx[i] = take_r ? nd_idx[2*i+2] : nd_idx[2*i+1];
    end

    assign victim_idx = nd_idx[0];

endmodule

// File: rtl/lru_tag_cam.sv
module lru_tag_cam
    import lru_cam_pkg::*;
#(
    parameter int ROWS  = 256,
    parameter int TAG_W = 14,
    parameter int AGE_W = 5,
    parameter int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_en,
    input  logic [TAG_W-1:0] srch_tag,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_row,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             hit_o,
    output logic             miss_o,
    output logic [IDX_W-1:0] hit_row_o,
    output logic [IDX_W-1:0] victim_row_o
);

    cam_state_e state_q, state_d;

    logic [ROWS-1:0]       row_valid;
    logic [ROWS-1:0]       match_vec;
    logic [ROWS-1:0]       acc_sel;
    logic [ROWS-1:0]       wr_sel;
    logic [ROWS*AGE_W-1:0] age_flat;
    logic [IDX_W-1:0]      match_idx;
    logic                  match_any;
    logic [IDX_W-1:0]      victim_idx;
    logic [IDX_W-1:0]      hit_row_q;
    logic [IDX_W-1:0]      victim_row_q;
    logic                  srch_go;
    logic                  acc_en;

    // A fill pre-empts both a search and a touch in the same cycle
    assign srch_go = srch_en && !fill_en;
    assign acc_en  = fill_en || touch_en;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign wr_sel[r]  = fill_en && (victim_row_q == IDX_W'(r));
        assign acc_sel[r] = fill_en ? wr_sel[r]
                                    : (touch_en && (touch_row == IDX_W'(r)));

        lru_cam_entry #(
            .TAG_W (TAG_W),
            .AGE_W (AGE_W)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .srch_tag (srch_tag),
            .acc_en   (acc_en),
            .acc_sel  (acc_sel[r]),
            .wr_sel   (wr_sel[r]),
            .wr_tag   (fill_tag),
            .valid_o  (row_valid[r]),
            .age_o    (age_flat[r*AGE_W +: AGE_W]),
            .match_o  (match_vec[r])
        );
    end

    lru_cam_enc #(
        .ROWS  (ROWS),
        .IDX_W (IDX_W)
    ) u_enc (
        .match_vec (match_vec),
        .match_idx (match_idx),
        .match_any (match_any)
    );

    lru_cam_victim #(
        .ROWS  (ROWS),
        .AGE_W (AGE_W),
        .IDX_W (IDX_W)
    ) u_victim (
        .row_valid  (row_valid),
        .age_flat   (age_flat),
        .victim_idx (victim_idx)
    );

    // Next-state decision: identical from every state
    always_comb begin
        state_d = ST_IDLE;
        if (srch_go) begin
            state_d = match_any ? ST_HIT : ST_MISS;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers, loaded only by an accepted search
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_row_q    <= '0;
            victim_row_q <= '0;
        end else if (srch_go) begin
            hit_row_q    <= match_idx;
            victim_row_q <= victim_idx;
        end
    end

    // Output decode from state
    always_comb begin
        hit_o  = 1'b0;
        miss_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                hit_o  = 1'b0;
                miss_o = 1'b0;
            end
            ST_HIT: begin
                hit_o  = 1'b1;
            end
            ST_MISS: begin
                miss_o = 1'b1;
            end
            default: begin
                hit_o  = 1'b0;
                miss_o = 1'b0;
            end
        endcase
    end

    assign hit_row_o    = hit_row_q;
    assign victim_row_o = victim_row_q;

endmodule

// File: rtl/lru_tag_cam_chk.sv
module lru_tag_cam_chk #(
    parameter int ROWS  = 256,
    parameter int AGE_W = 5,
    parameter int IDX_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  srch_en,
    input logic                  touch_en,
    input logic [IDX_W-1:0]      touch_row,
    input logic                  fill_en,
    input logic                  hit_o,
    input logic                  miss_o,
    input logic [IDX_W-1:0]      victim_row_o,
    input logic [ROWS-1:0]       row_valid,
    input logic [ROWS*AGE_W-1:0] age_flat,
    input logic [ROWS-1:0]       match_vec
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o)); // R2

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srch_en && !fill_en) |-> (hit_o || miss_o)); // R2

    AST_FILL_DROPS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o || miss_o) |-> $past(srch_en && !fill_en)); // R8

    AST_VICTIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(srch_en && !fill_en) |-> $stable(victim_row_o)); // R3

    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_o || miss_o) && !(&row_valid)) |-> !row_valid[victim_row_o]); // R4

    AST_TOUCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(touch_en && !fill_en) |->
            (age_flat[$past(touch_row)*AGE_W +: AGE_W] == '0)); // R6

    AST_FILL_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_en) |-> (row_valid[$past(victim_row_o)] &&
            (age_flat[$past(victim_row_o)*AGE_W +: AGE_W] == '0))); // R7

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R9

endmodule

bind lru_tag_cam lru_tag_cam_chk #(
    .ROWS  (ROWS),
    .AGE_W (AGE_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .srch_en      (srch_en),
    .touch_en     (touch_en),
    .touch_row    (touch_row),
    .fill_en      (fill_en),
    .hit_o        (hit_o),
    .miss_o       (miss_o),
    .victim_row_o (victim_row_o),
    .row_valid    (row_valid),
    .age_flat     (age_flat),
    .match_vec    (match_vec)
);

// File: tb/lru_tag_cam_bench.sv
module lru_tag_cam_bench;

    localparam int ROWS  = 256;
    localparam int TAG_W = 14;
    localparam int IDX_W = 8;
    localparam int AGE_MAX = 31;
    localparam time CLK_P = 8ns;

    localparam logic [1:0] OP_SRCH  = 2'd0;
    localparam logic [1:0] OP_FILL  = 2'd1;
    localparam logic [1:0] OP_TOUCH = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] arg;
        logic        exp_hit;
        logic [7:0]  exp_row;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{OP_SRCH,  16'h0000, 1'b0, 8'd0},  // R1 tag zero misses after reset
        '{OP_FILL,  16'h00AA, 1'b0, 8'd0},
        '{OP_SRCH,  16'h00AA, 1'b1, 8'd0},  // R2 hit row 0
        '{OP_SRCH,  16'h0111, 1'b0, 8'd1},  // R4 next invalid row
        '{OP_FILL,  16'h0111, 1'b0, 8'd0},
        '{OP_SRCH,  16'h0222, 1'b0, 8'd2},  // R4
        '{OP_FILL,  16'h0222, 1'b0, 8'd0},
        '{OP_TOUCH, 16'h0000, 1'b0, 8'd0},
        '{OP_SRCH,  16'h0111, 1'b1, 8'd1},  // R2 hit row 1
        '{OP_SRCH,  16'h3FFF, 1'b0, 8'd3}   // R4
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             srch_en = 1'b0;
    logic [TAG_W-1:0] srch_tag = '0;
    logic             touch_en = 1'b0;
    logic [IDX_W-1:0] touch_row = '0;
    logic             fill_en = 1'b0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic             hit_o;
    logic             miss_o;
    logic [IDX_W-1:0] hit_row_o;
    logic [IDX_W-1:0] victim_row_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model built from the requirements
    bit               m_valid [ROWS];
    logic [TAG_W-1:0] m_tag   [ROWS];
    int               m_age   [ROWS];
    int               m_vict;

    always #(CLK_P/2) clk = ~clk;

    lru_tag_cam u_lru_tag_cam (
        .clk          (clk),
        .rst_n        (rst_n),
        .srch_en      (srch_en),
        .srch_tag     (srch_tag),
        .touch_en     (touch_en),
        .touch_row    (touch_row),
        .fill_en      (fill_en),
        .fill_tag     (fill_tag),
        .hit_o        (hit_o),
        .miss_o       (miss_o),
        .hit_row_o    (hit_row_o),
        .victim_row_o (victim_row_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_victim();
        int best = -1;
        for (int r = 0; r < ROWS; r++) begin
            if (!m_valid[r]) return r;
        end
        for (int r = 0; r < ROWS; r++) begin
            if (best < 0 || m_age[r] > m_age[best]) best = r;
        end
        return best;
    endfunction

    function automatic int m_lookup(input logic [TAG_W-1:0] t);
        for (int r = 0; r < ROWS; r++) begin
            if (m_valid[r] && m_tag[r] == t) return r;
        end
        return -1;
    endfunction

    task automatic m_access(input int row);
        for (int r = 0; r < ROWS; r++) begin
            if (r == row) m_age[r] = 0;
            else if (m_valid[r] && m_age[r] < AGE_MAX) m_age[r]++;
        end
    endtask

    task automatic m_clear();
        for (int r = 0; r < ROWS; r++) begin
            m_valid[r] = 1'b0;
            m_tag[r]   = '0;
            m_age[r]   = 0;
        end
        m_vict = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        srch_en = 1'b0; touch_en = 1'b0; fill_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_clear();
    endtask

    task automatic do_search(input logic [TAG_W-1:0] t, input bit exp_hit,
                             input int exp_row, input string req);
        srch_en  = 1'b1;
        srch_tag = t;
        m_vict   = m_victim();
        @(negedge clk);
        srch_en = 1'b0;
        chk({req, " hit_o"}, int'(hit_o), int'(exp_hit));
        chk({req, " miss_o"}, int'(miss_o), int'(!exp_hit));
        if (exp_hit) chk({req, " hit_row_o"}, int'(hit_row_o), exp_row);
        else         chk({req, " victim_row_o"}, int'(victim_row_o), exp_row);
    endtask

    task automatic do_touch(input int row);
        touch_en  = 1'b1;
        touch_row = IDX_W'(row);
        m_access(row);
        @(negedge clk);
        touch_en = 1'b0;
    endtask

    task automatic do_fill(input logic [TAG_W-1:0] t);
        fill_en  = 1'b1;
        fill_tag = t;
        m_access(m_vict);
        m_valid[m_vict] = 1'b1;
        m_tag[m_vict]   = t;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Search whose expectation comes from the model
    task automatic model_search(input logic [TAG_W-1:0] t, input string req);
        int row;
        row = m_lookup(t);
        if (row >= 0) do_search(t, 1'b1, row, req);
        else          do_search(t, 1'b0, m_victim(), req);
    endtask

    initial begin
        int prev_vict;
        int old_row;
        m_clear();
        do_reset();

        // R1 reset state at the ports
        chk("R1 hit_o after reset", int'(hit_o), 0);
        chk("R1 miss_o after reset", int'(miss_o), 0);
        chk("R1 victim_row_o after reset", int'(victim_row_o), 0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            unique case (TBL[i].op)
                OP_SRCH:  do_search(TBL[i].arg[TAG_W-1:0], TBL[i].exp_hit,
                                    int'(TBL[i].exp_row), "R2 table");
                OP_FILL:  do_fill(TBL[i].arg[TAG_W-1:0]);
                OP_TOUCH: do_touch(int'(TBL[i].arg[IDX_W-1:0]));
                default:  ;
            endcase
        end

        // R2 idle cycle gives neither result
        @(negedge clk);
        chk("R2 hit_o idle", int'(hit_o), 0);
        chk("R2 miss_o idle", int'(miss_o), 0);

        // R8 fill and search in the same cycle
        prev_vict = int'(victim_row_o);
        srch_en  = 1'b1;
        srch_tag = 14'h0555;
        do_fill(14'h0333);
        srch_en = 1'b0;
        chk("R8 hit_o dropped", int'(hit_o), 0);
        chk("R8 miss_o dropped", int'(miss_o), 0);
        chk("R8 victim_row_o held", int'(victim_row_o), prev_vict);
        do_search(14'h0333, 1'b1, prev_vict, "R7 filled tag");
        do_search(14'h0555, 1'b0, m_victim(), "R8 dropped tag absent");

        // R4 fill every remaining row, lowest invalid first
        for (int n = 0; n < ROWS; n++) begin
            if (m_victim() >= 0 && !m_valid[m_victim()]) begin
                do_search(TAG_W'(14'h1000 + n), 1'b0, m_victim(), "R4 fill sweep");
                do_fill(TAG_W'(14'h1000 + n));
            end
        end

        // R5 all rows valid: oldest, lowest index on ties
        model_search(14'h2FFF, "R5 full store");

        // R6 long touch run drives ages past saturation
        for (int r = 0; r < 100; r++) do_touch(r);
        model_search(14'h2FFE, "R6 saturated ages");
        do_touch(m_vict);
        model_search(14'h2FFD, "R6 touched row leaves");

        // R7 replacing a valid row removes its old tag
        old_row = m_vict;
        begin
            logic [TAG_W-1:0] old_tag;
            old_tag = m_tag[old_row];
            do_fill(14'h2ABC);
            do_search(14'h2ABC, 1'b1, old_row, "R7 new tag");
            model_search(old_tag, "R7 old tag gone");
        end
        model_search(14'h00AA, "R2 early tag still present");

        // R1 reset in mid-run clears everything
        do_reset();
        chk("R1 hit_o after second reset", int'(hit_o), 0);
        do_search(14'h00AA, 1'b0, 0, "R1 store empty");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule